// File: doc/BRIEF.md
# Graphic Dot Colour Substitution and Keying Stage

This stage decides the final colour of one main-layer dot per clock. A graphic character stores a 4-bit colour for each dot in its font. Two attribute lanes can remap one stored colour each. The character lane remaps a chosen stored colour to the character's own colour. The border lane remaps a chosen stored colour to the row's border colour. After any remapping, an optional colour key makes every dot of one chosen colour see-through, so the colour of the layer beneath shows instead.

Dots that come from sprites, from the screen-background pattern, or from ordinary (non-graphic) characters skip the remapping. They still pass through the colour key. The result is registered once. It leaves one clock after the dot enters, with a valid flag and a visible flag beside it.

Top module: `gfx_color_resolver`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `out_valid`, `out_visible` and `out_color` are all 0.
- R2: `out_valid` equals `in_valid` from the previous clock. A cycle with `in_valid` low yields `out_color` = 0 and `out_visible` = 0 one clock later.
- R3: For a main-layer graphic dot (`src_tag` = 2'b00, `is_graphic` = 1) with `brd_rep_en` = 1 and `dot_code` = `brd_match`, where the character lane does not hit, the resolved colour is `border_color`.
- R4: For a main-layer graphic dot with `chr_rep_en` = 1 and `dot_code` = `chr_match`, the resolved colour is `char_color`.
- R5: When both lanes are enabled and both hit the same stored colour, the character lane wins, so the resolved colour is `char_color`.
- R6: With `key_en` = 1, a dot whose resolved colour equals `key_code` gives `out_visible` = 0 and `out_color` = `under_color`. Any other dot gives `out_visible` = 1 and `out_color` equal to the resolved colour.
- R7: When a lane's match code equals `key_code` and the stored colour hits that lane, the dot takes the lane's substitute colour. It is not keyed because of its stored colour.
- R8: When a substitute colour (`char_color` or `border_color`) equals `key_code` with `key_en` = 1, the substituted dot is keyed: `out_visible` = 0 and `out_color` = `under_color`.
- R9: Dots tagged sprite (2'b01), background pattern (2'b10) or spare (2'b11) are never remapped. Their resolved colour is `dot_code`, and they still take the colour key.
- R10: A main-layer dot with `is_graphic` = 0 is never remapped. Its resolved colour is `dot_code` (its foreground or background colour), and it still takes the colour key.
- R11: With `key_en` = 0, every valid dot is visible, even when its colour equals `key_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A dot is presented this cycle |
| src_tag | input | 2 | Layer source: 00 main, 01 sprite, 10 background pattern, 11 spare |
| is_graphic | input | 1 | Dot belongs to a graphic character |
| dot_code | input | 4 | Stored font colour, or the ordinary character's chosen colour |
| char_color | input | 4 | Colour attribute of the current character |
| border_color | input | 4 | Border colour attribute of the current row |
| chr_rep_en | input | 1 | Character-lane remapping enable |
| chr_match | input | 4 | Stored colour remapped by the character lane |
| brd_rep_en | input | 1 | Border-lane remapping enable |
| brd_match | input | 4 | Stored colour remapped by the border lane |
| key_en | input | 1 | Colour-key enable |
| key_code | input | 4 | Colour made see-through |
| under_color | input | 4 | Colour of the layer beneath this dot |
| out_valid | output | 1 | Registered dot valid |
| out_color | output | 4 | Registered final colour |
| out_visible | output | 1 | Registered flag: this layer is shown (not keyed) |

## Verification
The stage keeps no history beyond its single output register. A wrong lane order, a key test on the stored colour instead of the resolved one, or a missing source gate shows up as a bad `out_color` or `out_visible` on the very next clock, for that dot alone. A valid flag that slips or leaks shows as `out_valid` out of step with `in_valid` by one clock. Because each dot is independent, every fault is visible within one cycle of the stimulus that triggers it. The stimulus must therefore reach each priority case: both lanes hitting, a match code equal to the key, and a substitute equal to the key.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    // Layer source encoding carried with every dot
    typedef enum logic [1:0] {
        SRC_MAIN   = 2'b00,
        SRC_SPRITE = 2'b01,
        SRC_BGPAT  = 2'b10,
        SRC_SPARE  = 2'b11
    } gcr_src_e;

    // Substitution lanes, listed from highest to lowest priority
    localparam int unsigned LANE_CHR = 0;
    localparam int unsigned LANE_BRD = 1;
    localparam int unsigned N_LANES  = 2;

endpackage

// File: rtl/gcr_substitute.sv
module gcr_substitute #(
    parameter int unsigned COLOR_W = 4,
    parameter int unsigned LANES   = gcr_pkg::N_LANES
) (
    input  logic                          remap_ok,
    input  logic [COLOR_W-1:0]            dot_code,
    input  logic [LANES-1:0]              lane_en,
    input  logic [LANES-1:0][COLOR_W-1:0] lane_match,
    input  logic [LANES-1:0][COLOR_W-1:0] lane_color,
    output logic [COLOR_W-1:0]            res_color
);
    logic [LANES-1:0] lane_hit;

    // One comparator per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = remap_ok && lane_en[g] && (dot_code == lane_match[g]);
    end

    // Lowest lane index has priority: walk from the back so earlier lanes overwrite
    always_comb begin
        res_color = dot_code;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_hit[i]) begin
                res_color = lane_color[i];
            end
        end
    end
endmodule

// File: rtl/gcr_keyer.sv
module gcr_keyer #(
    parameter int unsigned COLOR_W = 4
) (
    input  logic               key_en,
    input  logic [COLOR_W-1:0] key_code,
    input  logic [COLOR_W-1:0] res_color,
    input  logic [COLOR_W-1:0] under_color,
    output logic [COLOR_W-1:0] final_color,
    output logic               visible
);
    logic keyed;

    // The key is tested against the colour left after substitution
    assign keyed       = key_en && (res_color == key_code);
    assign final_color = keyed ? under_color : res_color;
    assign visible     = !keyed;
endmodule

// File: rtl/gfx_color_resolver.sv
module gfx_color_resolver #(
    parameter int unsigned COLOR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         src_tag,
    input  logic               is_graphic,
    input  logic [COLOR_W-1:0] dot_code,
    input  logic [COLOR_W-1:0] char_color,
    input  logic [COLOR_W-1:0] border_color,
    input  logic               chr_rep_en,
    input  logic [COLOR_W-1:0] chr_match,
    input  logic               brd_rep_en,
    input  logic [COLOR_W-1:0] brd_match,
    input  logic               key_en,
    input  logic [COLOR_W-1:0] key_code,
    input  logic [COLOR_W-1:0] under_color,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color,
    output logic               out_visible
);
    import gcr_pkg::*;

    typedef struct packed {
        logic               vld;
        logic [COLOR_W-1:0] col;
        logic               vis;
    } stage_t;

    stage_t st_d, st_q;

    logic                            remap_ok;
    logic [N_LANES-1:0]              lane_en;
    logic [N_LANES-1:0][COLOR_W-1:0] lane_match;
    logic [N_LANES-1:0][COLOR_W-1:0] lane_color;
    logic [COLOR_W-1:0]              res_color;
    logic [COLOR_W-1:0]              final_color;
    logic                            visible;

    // Remapping is limited to graphic characters on the main layer
    assign remap_ok = (gcr_src_e'(src_tag) == SRC_MAIN) && is_graphic;

    // Fill the lanes in priority order
    assign lane_en[LANE_CHR]    = chr_rep_en;
    assign lane_match[LANE_CHR] = chr_match;
    assign lane_color[LANE_CHR] = char_color;
    assign lane_en[LANE_BRD]    = brd_rep_en;
    assign lane_match[LANE_BRD] = brd_match;
    assign lane_color[LANE_BRD] = border_color;

    gcr_substitute #(
        .COLOR_W (COLOR_W),
        .LANES   (N_LANES)
    ) sub_i (
        .remap_ok   (remap_ok),
        .dot_code   (dot_code),
        .lane_en    (lane_en),
        .lane_match (lane_match),
        .lane_color (lane_color),
        .res_color  (res_color)
    );

    gcr_keyer #(
        .COLOR_W (COLOR_W)
    ) key_i (
        .key_en      (key_en),
        .key_code    (key_code),
        .res_color   (res_color),
        .under_color (under_color),
        .final_color (final_color),
        .visible     (visible)
    );

    // Next-state computation
    always_comb begin
        st_d     = '0;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.col = final_color;
            st_d.vis = visible;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_color   = st_q.col;
    assign out_visible = st_q.vis;
endmodule

// File: rtl/gcr_checker.sv
module gcr_checker #(
    parameter int unsigned COLOR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         src_tag,
    input logic               is_graphic,
    input logic [COLOR_W-1:0] dot_code,
    input logic               key_en,
    input logic [COLOR_W-1:0] under_color,
    input logic               out_valid,
    input logic [COLOR_W-1:0] out_color,
    input logic               out_visible
);
    // R2: the valid flag trails the input by one clock
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: an idle slot is zeroed
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_color == '0) && !out_visible);
    // R11: nothing is keyed while the key is off
    p_nokey_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !key_en) |=> out_visible);
    // R6: a keyed dot carries the lower layer's colour
    p_keyed_under_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && key_en) |=> (out_visible || (out_color == $past(under_color))));
    // R9: non-main sources are never remapped
    p_bypass_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !key_en && (src_tag != 2'b00)) |=> (out_color == $past(dot_code)));
    // R10: ordinary characters are never remapped
    p_plain_char_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !key_en && !is_graphic) |=> (out_color == $past(dot_code)));
endmodule

bind gfx_color_resolver gcr_checker #(.COLOR_W(COLOR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_tag     (src_tag),
    .is_graphic  (is_graphic),
    .dot_code    (dot_code),
    .key_en      (key_en),
    .under_color (under_color),
    .out_valid   (out_valid),
    .out_color   (out_color),
    .out_visible (out_visible)
);

// File: tb/gfx_color_resolver_tb_top.sv
`timescale 1ns/1ps
module gfx_color_resolver_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] src_tag = 2'b00;
    logic       is_graphic = 1'b0;
    logic [3:0] dot_code = '0, char_color = '0, border_color = '0;
    logic       chr_rep_en = 1'b0, brd_rep_en = 1'b0, key_en = 1'b0;
    logic [3:0] chr_match = '0, brd_match = '0, key_code = '0, under_color = '0;
    logic       out_valid, out_visible;
    logic [3:0] out_color;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        bit    vld;
        int    col;
        bit    vis;
        string tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    gfx_color_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_tag(src_tag),
        .is_graphic(is_graphic), .dot_code(dot_code), .char_color(char_color),
        .border_color(border_color), .chr_rep_en(chr_rep_en), .chr_match(chr_match),
        .brd_rep_en(brd_rep_en), .brd_match(brd_match), .key_en(key_en),
        .key_code(key_code), .under_color(under_color), .out_valid(out_valid),
        .out_color(out_color), .out_visible(out_visible)
    );

    // Behavioural reference built from the requirements
    function automatic exp_t model(string tag);
        exp_t e;
        int   c;
        e.tag = tag;
        if (!in_valid) begin
            e.vld = 0; e.col = 0; e.vis = 0;
            return e;
        end
        c = int'(dot_code);
        if (src_tag == 2'b00 && is_graphic) begin
            if (chr_rep_en && dot_code == chr_match)      c = int'(char_color);
            else if (brd_rep_en && dot_code == brd_match) c = int'(border_color);
        end
        e.vld = 1;
        if (key_en && c == int'(key_code)) begin
            e.col = int'(under_color); e.vis = 0;
        end else begin
            e.col = c; e.vis = 1;
        end
        return e;
    endfunction

    task automatic check_now(exp_t e);
        n_tests++;
        if (out_valid !== e.vld || int'(out_color) != e.col || out_visible !== e.vis) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b col=%0d vis=%0b, expected vld=%0b col=%0d vis=%0b",
                     e.tag, out_valid, out_color, out_visible, e.vld, e.col, e.vis);
        end
    endtask

    // Inputs were set just after a falling edge; result is sampled at the next falling edge
    task automatic step(string tag);
        exp_t e;
        expq.push_back(model(tag));
        @(negedge clk);
        e = expq.pop_front();
        check_now(e);
    endtask

    task automatic clear_in();
        in_valid = 1; src_tag = 2'b00; is_graphic = 1;
        chr_rep_en = 0; brd_rep_en = 0; key_en = 0;
        chr_match = 0; brd_match = 0; key_code = 0;
        dot_code = 0; char_color = 0; border_color = 0; under_color = 0;
    endtask

    task automatic check_reset(string tag);
        exp_t e;
        e.vld = 0; e.col = 0; e.vis = 0; e.tag = tag;
        check_now(e);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1 during reset");
        rst_n = 1;
        @(negedge clk);
        check_reset("R1 after release");

        // R3 border lane
        clear_in(); brd_rep_en = 1; brd_match = 5; dot_code = 5; border_color = 9;
        step("R3 border hit");
        dot_code = 6;
        step("R3 border miss");
        // R4 character lane
        clear_in(); chr_rep_en = 1; chr_match = 7; dot_code = 7; char_color = 12;
        step("R4 char hit");
        // R5 both lanes on one code
        clear_in(); chr_rep_en = 1; brd_rep_en = 1; chr_match = 3; brd_match = 3;
        dot_code = 3; char_color = 1; border_color = 2;
        step("R5 char over border");
        // R6 keying
        clear_in(); key_en = 1; key_code = 4; dot_code = 4; under_color = 11;
        step("R6 keyed");
        dot_code = 5;
        step("R6 not keyed");
        // R7 match code equals key code
        clear_in(); key_en = 1; key_code = 4; brd_rep_en = 1; brd_match = 4;
        dot_code = 4; border_color = 8; under_color = 13;
        step("R7 border wins over key");
        clear_in(); key_en = 1; key_code = 6; chr_rep_en = 1; chr_match = 6;
        dot_code = 6; char_color = 10; under_color = 13;
        step("R7 char wins over key");
        // R8 substitute is the key colour
        clear_in(); key_en = 1; key_code = 4; brd_rep_en = 1; brd_match = 2;
        dot_code = 2; border_color = 4; under_color = 13;
        step("R8 border substitute keyed");
        clear_in(); key_en = 1; key_code = 15; chr_rep_en = 1; chr_match = 1;
        dot_code = 1; char_color = 15; under_color = 7;
        step("R8 char substitute keyed");
        // R9 non-main sources bypass
        for (int t = 1; t < 4; t++) begin
            clear_in(); src_tag = 2'(t); chr_rep_en = 1; brd_rep_en = 1;
            chr_match = 9; brd_match = 9; dot_code = 9; char_color = 2; border_color = 3;
            step("R9 source bypass");
            key_en = 1; key_code = 9; under_color = 14;
            step("R9 source still keyed");
        end
        // R10 ordinary characters bypass
        clear_in(); is_graphic = 0; chr_rep_en = 1; chr_match = 8; dot_code = 8; char_color = 1;
        step("R10 plain char bypass");
        key_en = 1; key_code = 8; under_color = 5;
        step("R10 plain char keyed");
        // R11 key off
        clear_in(); key_code = 3; dot_code = 3;
        step("R11 key off visible");
        // R2 idle slots and back-to-back
        clear_in(); dot_code = 10;
        step("R2 valid");
        in_valid = 0;
        step("R2 idle zeroed");
        in_valid = 1; dot_code = 12;
        step("R2 resume");

        // Randomised pass on a narrow code set so hits are frequent
        for (int i = 0; i < 400; i++) begin
            in_valid = ($urandom_range(0, 7) != 0);
            src_tag = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            is_graphic = ($urandom_range(0, 4) != 0);
            dot_code = 4'($urandom_range(0, 3));
            chr_match = 4'($urandom_range(0, 3));
            brd_match = 4'($urandom_range(0, 3));
            key_code = 4'($urandom_range(0, 3));
            char_color = 4'($urandom_range(0, 5));
            border_color = 4'($urandom_range(0, 5));
            under_color = 4'($urandom_range(0, 15));
            chr_rep_en = 1'($urandom_range(0, 1));
            brd_rep_en = 1'($urandom_range(0, 1));
            key_en = 1'($urandom_range(0, 1));
            step("R3 R4 R5 R6 R7 R8 random");
        end

        // Reset in mid-stream
        clear_in(); dot_code = 7;
        rst_n = 0;
        @(negedge clk);
        check_reset("R1 mid-run reset");
        rst_n = 1; in_valid = 0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule